// File: doc/BRIEF.md
# Five-Tap Edge-Reflecting Tap Index Generator

This block feeds the sample addresses of a five-tap filter that walks along one line segment of up to 64 pixels. For each requested output position it returns the five pixel indices the filter must read: two before the centre, the centre itself, and two after it. Near either end of the segment, an index that would fall outside the segment is reflected back about the end pixel. The end pixel is not repeated, so the filter never reads outside the segment and the end pixel appears once, at the centre of the reflection.

A request carries the centre position (zero-based) and the segment length. Short segments, down to three pixels, are accepted, so the first and last columns of an image that does not start or end on a block boundary can be handled. Results are registered and appear one clock after the request, together with a valid flag. A request that is malformed produces no valid result and leaves the previous taps unchanged.

Top module: `edge_mirror_taps`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and taps_o is all zeros.
- R2: valid_o is high in the cycle after an accepted request and low in the cycle after any other cycle. A request is accepted when valid_i is 1, len_i is between 3 and 64 inclusive, and pos_i < len_i.
- R3: taps_o holds five 6-bit indices. Tap k sits in bits [6k+5:6k] and has the nominal value pos+k-2, so tap 0 is the leftmost and tap 4 is the rightmost. When every nominal value lies in 0..len-1, the taps equal the nominal values.
- R4: A nominal value v below 0 is replaced by -v. For position 0 this gives 2,1,0,1,2, and for position 1 it gives 1,0,1,2,3.
- R5: A nominal value v above len-1 is replaced by 2(len-1)-v. For position len-1 this gives len-3,len-2,len-1,len-2,len-3, and for position len-2 it gives len-4,len-3,len-2,len-1,len-2.
- R6: When len is 3 and the position is 1, the taps reflect at both ends in the same result, giving 1,0,1,2,1.
- R7: A request that is not accepted leaves taps_o unchanged.
- R8: Every tap of a valid result is below the len of its request.
- R9: The centre tap (tap 2) of a valid result equals the requested position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| pos_i | input | 6 | Centre pixel position, zero-based |
| len_i | input | 7 | Segment length in pixels |
| valid_o | output | 1 | Result valid, one cycle after an accepted request |
| taps_o | output | 30 | Five packed tap indices, tap 0 in the low bits |

## Verification
Reflection at the left end and reflection at the right end coincide in a single result only when the segment is three pixels long and the centre pixel is requested. The bench sends that case on purpose, within sweeps of every position at lengths 3, 4, 5 and 64 and among random lengths. A behavioural model in the bench derives each tap from the nominal index and the two reflection rules, and the design's result is compared with it on every clock. Rejected requests are mixed between accepted ones, so that the held taps and the low valid flag are checked in the same stream.

// File: rtl/tapsel_pkg.sv
package tapsel_pkg;
  localparam int unsigned NUM_TAPS   = 5;
  localparam int unsigned HALF_TAPS  = NUM_TAPS / 2;
  localparam int unsigned MIN_SEGLEN = 3;
endpackage

// File: rtl/tapsel_req_check.sv
module tapsel_req_check #(
  parameter int unsigned MAX_LEN = 64,
  parameter int unsigned MIN_LEN = 3,
  localparam int unsigned IDX_W  = $clog2(MAX_LEN),
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic             valid_i,
  input  logic [IDX_W-1:0] pos_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             ok_o,
  output logic [IDX_W-1:0] last_o
);
  localparam logic [LEN_W-1:0] LO = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] HI = LEN_W'(MAX_LEN);

  logic [LEN_W-1:0] pos_ext;
  logic [LEN_W-1:0] last_full;

  assign pos_ext   = LEN_W'(pos_i);
  assign last_full = len_i - LEN_W'(1);
  assign ok_o      = valid_i && (len_i >= LO) && (len_i <= HI) && (pos_ext < len_i);
  assign last_o    = last_full[IDX_W-1:0];
endmodule

// File: rtl/tapsel_mirror.sv
module tapsel_mirror #(
  parameter int unsigned IDX_W  = 6,
  parameter int          OFFSET = 0
) (
  input  logic             en_i,
  input  logic [IDX_W-1:0] pos_i,
  input  logic [IDX_W-1:0] last_i,
  output logic [IDX_W-1:0] tap_o
);
  localparam int unsigned SW = IDX_W + 3;
  localparam logic signed [SW-1:0] OFF_S = SW'(OFFSET);

  logic signed [SW-1:0] raw, last_s, res;

  always_comb begin
    raw    = $signed({3'b000, pos_i}) + OFF_S;
    last_s = $signed({3'b000, last_i});
    if (raw < 0)           res = -raw;
    else if (raw > last_s) res = (last_s <<< 1) - raw;
    else                   res = raw;
    tap_o = res[IDX_W-1:0];
  end

  // R8
  always_comb begin
    if (en_i) begin
      mirror_range_chk: assert (res >= 0 && res <= last_s)
        else $error("reflected tap out of segment");
    end
  end
endmodule

// File: rtl/edge_mirror_taps.sv
module edge_mirror_taps
  import tapsel_pkg::*;
#(
  parameter int unsigned MAX_LEN = 64,
  localparam int unsigned IDX_W  = $clog2(MAX_LEN),
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1),
  localparam int unsigned TAPS_W = NUM_TAPS * IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [IDX_W-1:0]  pos_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              valid_o,
  output logic [TAPS_W-1:0] taps_o
);
  logic              req_ok;
  logic [IDX_W-1:0]  last_idx;
  logic [TAPS_W-1:0] taps_d;

  tapsel_req_check #(
    .MAX_LEN(MAX_LEN),
    .MIN_LEN(MIN_SEGLEN)
  ) u_req (
    .valid_i(valid_i),
    .pos_i  (pos_i),
    .len_i  (len_i),
    .ok_o   (req_ok),
    .last_o (last_idx)
  );

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    tapsel_mirror #(
      .IDX_W (IDX_W),
      .OFFSET(k - int'(HALF_TAPS))
    ) u_mir (
      .en_i  (req_ok),
      .pos_i (pos_i),
      .last_i(last_idx),
      .tap_o (taps_d[k*IDX_W +: IDX_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      taps_o  <= '0;
    end else begin
      valid_o <= req_ok;
      if (req_ok) taps_o <= taps_d;
    end
  end

  // R2
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && len_i >= LEN_W'(MIN_SEGLEN) && len_i <= LEN_W'(MAX_LEN)
          && LEN_W'(pos_i) < len_i) |-> valid_o);

  // R2
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> !valid_o);

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(taps_o));

  // R9
  centre_tap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> taps_o[HALF_TAPS*IDX_W +: IDX_W] == $past(pos_i));

  // R6
  both_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(len_i) == LEN_W'(3) && $past(pos_i) == IDX_W'(1))
    |-> (taps_o[0 +: IDX_W] == taps_o[2*IDX_W +: IDX_W]
         && taps_o[4*IDX_W +: IDX_W] == taps_o[2*IDX_W +: IDX_W]));

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_bound
    // R8
    tap_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> LEN_W'(taps_o[k*IDX_W +: IDX_W]) < $past(len_i));
  end
endmodule

// File: tb/tb_edge_mirror_taps.sv
module tb_edge_mirror_taps;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [5:0]  pos_i = '0;
  logic [6:0]  len_i = '0;
  logic        valid_o;
  logic [29:0] taps_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference model state
  bit    exp_valid = 0;
  int    exp_tap[5];
  int    exp_pos = 0;
  int    exp_len = 0;
  string exp_tag = "R1";

  always #2 clk_i = ~clk_i;

  edge_mirror_taps dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .pos_i  (pos_i),
    .len_i  (len_i),
    .valid_o(valid_o),
    .taps_o (taps_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  initial for (int k = 0; k < 5; k++) exp_tap[k] = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_valid = 0;
      for (int k = 0; k < 5; k++) exp_tap[k] = 0;
      exp_tag = "R1";
    end else begin
      int p, n;
      bit acc, lhit, rhit;
      p = int'(pos_i);
      n = int'(len_i);
      acc = valid_i && n >= 3 && n <= 64 && p < n;
      exp_valid = acc;
      if (acc) begin
        lhit = 0; rhit = 0;
        for (int k = 0; k < 5; k++) begin
          int v;
          v = p + k - 2;
          if (v < 0) begin v = -v; lhit = 1; end
          else if (v > n - 1) begin v = 2 * (n - 1) - v; rhit = 1; end
          exp_tap[k] = v;
        end
        exp_pos = p;
        exp_len = n;
        exp_tag = (lhit && rhit) ? "R6" : lhit ? "R4" : rhit ? "R5" : "R3";
      end else begin
        exp_tag = "R7";
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      check(exp_tag == "R7" ? "R7" : "R2", int'(valid_o), int'(exp_valid));
      for (int k = 0; k < 5; k++)
        check(exp_tag, int'(taps_o[k*6 +: 6]), exp_tap[k]);
      if (valid_o) begin
        // R9: centre equals requested position
        check("R9", int'(taps_o[12 +: 6]), exp_pos);
        // R8: every tap inside the segment
        for (int k = 0; k < 5; k++)
          check("R8", int'(int'(taps_o[k*6 +: 6]) < exp_len), 1);
      end
    end
  end

  task automatic req(input bit v, input int p, input int n);
    @(negedge clk_i);
    valid_i = v;
    pos_i = 6'(p);
    len_i = 7'(n);
  endtask

  task automatic sweep(input int n);
    for (int p = 0; p < n; p++) req(1'b1, p, n);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1", int'(valid_o), 0);
    check("R1", int'(taps_o), 0);
    rst_ni = 1'b1;
    req(1'b0, 0, 0);
    sweep(64);
    sweep(3);    // R6 at position 1
    sweep(4);
    sweep(5);
    req(1'b1, 1, 3);
    req(1'b0, 1, 3);   // R7 idle
    req(1'b1, 5, 5);   // R7 pos == len
    req(1'b1, 1, 2);   // R7 len too short
    req(1'b1, 0, 65);  // R7 len too long
    req(1'b1, 0, 0);
    req(1'b1, 63, 64);
    for (int i = 0; i < 3000; i++) begin
      int n, p;
      n = 3 + int'($urandom_range(0, 61));
      p = int'($urandom_range(0, 63));
      req(($urandom_range(0, 7) != 0), p, n);
    end
    for (int n = 3; n <= 64; n++) begin
      req(1'b1, 0, n);
      req(1'b1, n - 1, n);
      req(1'b1, n - 2, n);
    end
    req(1'b0, 0, 0);
    @(negedge clk_i);
    @(negedge clk_i);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule